// File: doc/BRIEF.md
# CAN Frame Start and Error Trigger

This block follows a stream of CAN bit values that an upstream sampler has already recovered, one value per strobe on `bit_vld`, and emits a one-cycle trigger pulse. It has two modes. In start mode it fires on the dominant start bit of every frame. In error mode it fires on any detected error class whose bit is set in a mask. The error classes are error flag, stuff violation and CRC mismatch.

To find stuff and CRC errors, the block tracks the standard-identifier data frame one field at a time. It removes stuff bits and runs a 15-bit CRC over the destuffed header and payload. It then compares the result with the transmitted check sequence. After any error the tracker drops back to idle. A new frame can start only once the bus has shown a fresh idle period.

Top module: `can_err_trig`

## Requirements
- R1: While `rst` is high and after it, with no strobes, `trig` is 0.
- R2: With `mode`=0 (start mode), `trig` pulses in the cycle after a strobe that carries a dominant (0) bit, provided at least 11 recessive (1) bits were seen before it. No other bit of that frame produces a pulse.
- R3: A dominant bit that follows fewer than 11 consecutive recessive bits is not taken as a start bit.
- R4: Between the start bit and the last CRC bit (including one stuff bit directly after the last CRC bit), the bit after five equal bits is a stuff bit. It is dropped from decoding. Correctly stuffed frames with a correct CRC raise no error.
- R5: A stuff error is detected when the bit in a stuff position has the same value as the five bits before it.
- R6: An error flag is detected on the sixth consecutive dominant bit. A longer dominant run produces it only once.
- R7: The CRC uses polynomial 0x4599 and a zero start value. It covers the destuffed bits from the start bit through the last data bit. A CRC error is detected on the 15th (last) CRC bit when the received sequence, sent MSB first, differs from the computed value.
- R8: The frame layout is: start bit, 11-bit identifier, three control bits, 4-bit DLC (MSB first), then 8·min(DLC,8) data bits and 15 CRC bits. A DLC above 8 means 8 data bytes.
- R9: With `mode`=1 (error mode), `trig` pulses only when a detected error has its mask bit set. Bit 0 of `err_mask` is the error flag, bit 1 is the stuff error and bit 2 is the CRC error. In start mode, errors do not pulse `trig`.
- R10: After any error the tracker is idle and the recessive-run count restarts from zero. A start then needs 11 new recessive bits.
- R11: `trig` is high only in the cycle after a strobe, and for one cycle per event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe: one recovered bus bit is present |
| bit_val | input | 1 | Bit value, 0 dominant, 1 recessive |
| mode | input | 1 | 0 start-of-frame trigger, 1 error trigger |
| err_mask | input | 3 | Error class enables: [0] flag, [1] stuff, [2] CRC |
| trig | output | 1 | Single-cycle trigger pulse |

## Verification
The bench uses the default parameters: an 11-bit idle gap, a stuff run of 5, a flag length of 6 and at most 8 data bytes. With these defaults, frames with DLC 0, 1, 2, 3, 8 and 15 fit in one short run, so the clamping of DLC values above 8 is tested against a CRC computed independently. An all-zero identifier and payload force dense stuffing. A corrupted check sequence and an inverted stuff bit place each error on a known bit. Idle gaps one bit short of the threshold, after a frame and after an error, test the recessive-run restart.

// File: rtl/can_trig_pkg.sv
package can_trig_pkg;

    localparam int CRC_W      = 15;
    localparam logic [CRC_W-1:0] CRC_POLY = 15'h4599;
    localparam int ID_BITS    = 11;
    localparam int CTL_BITS   = 3;
    localparam int DLC_BITS   = 4;
    localparam int TAIL_BITS  = 10;   // CRC delimiter, ACK slot, ACK delimiter, 7 EOF

    typedef enum logic [2:0] {
        FS_IDLE, FS_ID, FS_CTL, FS_DLC, FS_DATA, FS_CRC, FS_TAIL
    } fstate_e;

    typedef enum logic {
        TM_SOF = 1'b0,
        TM_ERR = 1'b1
    } trig_mode_e;

    // bit order matches err_mask: [2] crc, [1] stuff, [0] flag
    typedef struct packed {
        logic crc;
        logic stuff;
        logic flag;
    } err_t;

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/can_bus_watch.sv
module can_bus_watch #(
    parameter int IDLE_BITS = 11,
    parameter int FLAG_LEN  = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_val,
    input  logic restart,
    output logic idle_ok,
    output logic flag_err
);
    localparam int RW = $clog2(IDLE_BITS + 1);
    localparam int DW = $clog2(FLAG_LEN + 1);
    localparam logic [RW-1:0] REC_MAX = RW'(IDLE_BITS);
    localparam logic [DW-1:0] DOM_MAX = DW'(FLAG_LEN);
    localparam logic [DW-1:0] DOM_HIT = DW'(FLAG_LEN - 1);

    logic [RW-1:0] rec_cnt;
    logic [DW-1:0] dom_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec_cnt <= '0;
            dom_cnt <= '0;
        end else if (bit_vld) begin
            if (restart || !bit_val)
                rec_cnt <= '0;
            else if (rec_cnt != REC_MAX)
                rec_cnt <= rec_cnt + RW'(1);

            if (bit_val)
                dom_cnt <= '0;
            else if (dom_cnt != DOM_MAX)
                dom_cnt <= dom_cnt + DW'(1);
        end
    end

    assign idle_ok  = (rec_cnt == REC_MAX);
    assign flag_err = bit_vld && !bit_val && (dom_cnt == DOM_HIT);

endmodule

// File: rtl/can_destuff.sv
module can_destuff #(
    parameter int STUFF_LEN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_val,
    input  logic start,
    input  logic active,
    output logic dat_vld,
    output logic stuff_err
);
    localparam int RW = $clog2(STUFF_LEN + 1);
    localparam logic [RW-1:0] RUN_MAX = RW'(STUFF_LEN);

    logic [RW-1:0] run;
    logic          last_b;
    logic          slot;

    assign slot      = active && (run == RUN_MAX);
    assign stuff_err = bit_vld && slot && (bit_val == last_b);
    assign dat_vld   = bit_vld && !slot;

    always_ff @(posedge clk) begin
        if (rst) begin
            run    <= '0;
            last_b <= 1'b1;
        end else if (bit_vld && start) begin
            run    <= RW'(1);
            last_b <= bit_val;
        end else if (bit_vld && active) begin
            if (slot || bit_val != last_b)
                run <= RW'(1);
            else
                run <= run + RW'(1);
            last_b <= bit_val;
        end
    end

endmodule

// File: rtl/can_frame_fsm.sv
module can_frame_fsm
    import can_trig_pkg::*;
#(
    parameter int MAX_BYTES = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_val,
    input  logic dat_vld,
    input  logic start,
    input  logic ext_abort,
    output logic st_idle,
    output logic stuff_active,
    output logic crc_err
);
    localparam int DB = MAX_BYTES * 8;
    localparam int CW = (DB >= 16) ? $clog2(DB + 1) : 5;
    localparam logic [3:0] DLC_CAP = 4'((MAX_BYTES > 15) ? 15 : MAX_BYTES);

    fstate_e          st;
    logic [CW-1:0]    cnt, flen;
    logic [3:0]       dlc_q, dlc_full, nbytes;
    logic [CRC_W-1:0] crc_calc, crc_rx;
    logic             last;

    always_comb begin
        dlc_full = {dlc_q[2:0], bit_val};
        nbytes   = (dlc_q > DLC_CAP) ? DLC_CAP : dlc_q;
        case (st)
            FS_ID:   flen = CW'(ID_BITS);
            FS_CTL:  flen = CW'(CTL_BITS);
            FS_DLC:  flen = CW'(DLC_BITS);
            FS_DATA: flen = CW'({nbytes, 3'b000});
            FS_CRC:  flen = CW'(CRC_W);
            FS_TAIL: flen = CW'(TAIL_BITS);
            default: flen = CW'(1);
        endcase
        last = (cnt == flen - CW'(1));
    end

    assign st_idle      = (st == FS_IDLE);
    assign stuff_active = (st == FS_ID) || (st == FS_CTL) || (st == FS_DLC) ||
                          (st == FS_DATA) || (st == FS_CRC) ||
                          (st == FS_TAIL && cnt == '0);
    assign crc_err      = dat_vld && (st == FS_CRC) && last &&
                          ({crc_rx[CRC_W-2:0], bit_val} != crc_calc);

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= FS_IDLE;
            cnt      <= '0;
            dlc_q    <= '0;
            crc_calc <= '0;
            crc_rx   <= '0;
        end else if (bit_vld && (ext_abort || crc_err)) begin
            st <= FS_IDLE;
        end else if (start) begin
            st       <= FS_ID;
            cnt      <= '0;
            crc_calc <= crc_step('0, 1'b0);
            crc_rx   <= '0;
        end else if (dat_vld && st != FS_IDLE) begin
            cnt <= last ? '0 : cnt + CW'(1);
            if (st inside {FS_ID, FS_CTL, FS_DLC, FS_DATA})
                crc_calc <= crc_step(crc_calc, bit_val);
            if (st == FS_DLC)
                dlc_q <= dlc_full;
            if (st == FS_CRC)
                crc_rx <= {crc_rx[CRC_W-2:0], bit_val};
            if (last) begin
                case (st)
                    FS_ID:   st <= FS_CTL;
                    FS_CTL:  st <= FS_DLC;
                    FS_DLC:  st <= (dlc_full == 4'd0) ? FS_CRC : FS_DATA;
                    FS_DATA: st <= FS_CRC;
                    FS_CRC:  st <= FS_TAIL;
                    default: st <= FS_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/can_err_trig.sv
module can_err_trig
    import can_trig_pkg::*;
#(
    parameter int IDLE_BITS = 11,
    parameter int STUFF_LEN = 5,
    parameter int FLAG_LEN  = 6,
    parameter int MAX_BYTES = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_vld,
    input  logic       bit_val,
    input  logic       mode,
    input  logic [2:0] err_mask,
    output logic       trig
);
    err_t errs;
    logic flag_err, stuff_err, crc_err, any_err;
    logic idle_ok, fsm_idle, stuff_active, dat_vld, start, hit;

    assign start = bit_vld && !bit_val && idle_ok && fsm_idle;

    always_comb begin
        errs.flag  = flag_err;
        errs.stuff = stuff_err;
        errs.crc   = crc_err;
    end
    assign any_err = |errs;

    can_bus_watch #(.IDLE_BITS(IDLE_BITS), .FLAG_LEN(FLAG_LEN)) u_watch (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val),
        .restart(any_err), .idle_ok(idle_ok), .flag_err(flag_err)
    );

    can_destuff #(.STUFF_LEN(STUFF_LEN)) u_destuff (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val),
        .start(start), .active(stuff_active),
        .dat_vld(dat_vld), .stuff_err(stuff_err)
    );

    can_frame_fsm #(.MAX_BYTES(MAX_BYTES)) u_fsm (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val),
        .dat_vld(dat_vld), .start(start), .ext_abort(flag_err || stuff_err),
        .st_idle(fsm_idle), .stuff_active(stuff_active), .crc_err(crc_err)
    );

    assign hit = (trig_mode_e'(mode) == TM_ERR) ? |(3'(errs) & err_mask) : start;

    always_ff @(posedge clk) begin
        if (rst) trig <= 1'b0;
        else     trig <= hit;
    end

endmodule

// File: rtl/can_err_trig_chk.sv
module can_err_trig_chk (
    input logic       clk,
    input logic       rst,
    input logic       bit_vld,
    input logic       bit_val,
    input logic       mode,
    input logic [2:0] err_mask,
    input logic       trig,
    input logic       any_err,
    input logic       fsm_idle,
    input logic       idle_ok
);
    AST_TRIG_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        trig |-> $past(bit_vld)); // R11

    AST_START_IS_DOMINANT: assert property (@(posedge clk) disable iff (rst)
        (trig && !$past(mode)) |-> !$past(bit_val)); // R2

    AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (trig && !$past(mode)) |-> $past(idle_ok)); // R3

    AST_MASK_GATES: assert property (@(posedge clk) disable iff (rst)
        (trig && $past(mode)) |-> ($past(err_mask) != 3'b000)); // R9

    AST_IDLE_AFTER_ERR: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && any_err) |=> (fsm_idle && !idle_ok)); // R10
endmodule

bind can_err_trig can_err_trig_chk u_chk (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val), .mode(mode),
    .err_mask(err_mask), .trig(trig), .any_err(any_err),
    .fsm_idle(fsm_idle), .idle_ok(idle_ok)
);

// File: tb/can_err_trig_test.sv
`timescale 1ns/1ps
module can_err_trig_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_vld = 1'b0;
    logic       bit_val = 1'b1;
    logic       mode = 1'b0;
    logic [2:0] err_mask = 3'b000;
    logic       trig;

    always #2.5 clk = ~clk;

    can_err_trig uut (
        .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_val(bit_val),
        .mode(mode), .err_mask(err_mask), .trig(trig)
    );

    typedef struct {
        bit    exp;
        string tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int   checks = 0;
    int   fails  = 0;
    logic fr[$];
    int   crc_last_idx;
    int   first_stuff_idx;

    // frame builder: independent reference of layout, CRC and stuffing
    task automatic build(input logic [10:0] id, input logic [3:0] dlc,
                         input logic [63:0] data, input bit bad_crc);
        logic        raw[$];
        logic [14:0] crc;
        logic        fb, last_b;
        int          nb, run;
        crc = '0;
        raw.push_back(1'b0);
        for (int i = 10; i >= 0; i--) raw.push_back(id[i]);
        for (int i = 0; i < 3; i++) raw.push_back(1'b0);
        for (int i = 3; i >= 0; i--) raw.push_back(dlc[i]);
        nb = (dlc > 8) ? 8 : int'(dlc);
        for (int i = 0; i < nb * 8; i++) raw.push_back(data[63 - i]);
        foreach (raw[i]) begin
            fb  = raw[i] ^ crc[14];
            crc = {crc[13:0], 1'b0};
            if (fb) crc = crc ^ 15'h4599;
        end
        if (bad_crc) crc[0] = ~crc[0];
        for (int i = 14; i >= 0; i--) raw.push_back(crc[i]);
        fr.delete();
        first_stuff_idx = -1;
        run = 0;
        last_b = 1'b1;
        for (int i = 0; i < raw.size(); i++) begin
            fr.push_back(raw[i]);
            if (i > 0 && raw[i] == last_b) run++;
            else run = 1;
            last_b = raw[i];
            if (i == raw.size() - 1) crc_last_idx = fr.size() - 1;
            if (run == 5) begin
                if (first_stuff_idx < 0) first_stuff_idx = fr.size();
                fr.push_back(~last_b);
                last_b = ~last_b;
                run = 1;
            end
        end
        fr.push_back(1'b1); fr.push_back(1'b0); fr.push_back(1'b1);
        for (int i = 0; i < 7; i++) fr.push_back(1'b1);
    endtask

    task automatic send_bit(input logic b, input bit exp, input string tag);
        sb_item_t it;
        @(negedge clk);
        bit_vld = 1'b1;
        bit_val = b;
        @(negedge clk);
        bit_vld = 1'b0;
        bit_val = 1'b1;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic send_idle(input int n, input string tag);
        for (int i = 0; i < n; i++) send_bit(1'b1, 1'b0, tag);
    endtask

    task automatic send_frame(input int n, input int tidx, input string tag);
        for (int i = 0; i < n; i++) send_bit(fr[i], i == tidx, tag);
    endtask

    // monitor: pops one expected trig value per strobe
    initial begin
        sb_item_t it;
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                it = sb_q.pop_front();
                checks++;
                if (trig !== it.exp) begin
                    fails++;
                    $display("FAIL %s trig=%b expected=%b", it.tag, trig, it.exp);
                end
            end else if (!rst && trig !== 1'b0) begin
                checks++;
                fails++;
                $display("FAIL R11 trig=%b expected=0 without strobe", trig);
            end
        end
    end

    initial begin
        #(5.0 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog trig=%b expected=completion", trig);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (trig !== 1'b0) begin
            fails++;
            $display("FAIL R1 trig=%b expected=0", trig);
        end
        rst = 1'b0;

        // R2: start mode fires on the start bit only
        mode = 1'b0;
        send_idle(11, "R2");
        build(11'h123, 4'd2, {16'hA55A, 48'h0}, 1'b0);
        send_frame(fr.size(), 0, "R2");

        // R3: 8 tail recessive + 2 = 10, one short
        send_idle(2, "R3");
        send_bit(1'b0, 1'b0, "R3");
        send_idle(11, "R2");
        build(11'h5A5, 4'd0, 64'h0, 1'b0);
        send_frame(fr.size(), 0, "R2");

        // R4 / R8: clean frames raise no error in error mode
        mode = 1'b1;
        err_mask = 3'b111;
        send_idle(11, "R4");
        build(11'h000, 4'd8, 64'h0, 1'b0);
        send_frame(fr.size(), -1, "R4");
        send_idle(11, "R8");
        build(11'h2AB, 4'd15, 64'hFFFF_0000_1234_8001, 1'b0);
        send_frame(fr.size(), -1, "R8");
        send_idle(11, "R4");
        build(11'h7FF, 4'd1, {8'hFF, 56'h0}, 1'b0);
        send_frame(fr.size(), -1, "R4");

        // R7: corrupted check sequence fires on last CRC bit
        err_mask = 3'b100;
        send_idle(11, "R7");
        build(11'h321, 4'd3, {24'hC0FFEE, 40'h0}, 1'b1);
        send_frame(crc_last_idx + 1, crc_last_idx, "R7");

        // R9: CRC class masked off
        err_mask = 3'b011;
        send_idle(11, "R9");
        send_frame(crc_last_idx + 1, -1, "R9");

        // R5: inverted stuff bit
        err_mask = 3'b010;
        send_idle(11, "R5");
        build(11'h7F0, 4'd1, {8'h3C, 56'h0}, 1'b0);
        fr[first_stuff_idx] = ~fr[first_stuff_idx];
        send_frame(first_stuff_idx + 1, first_stuff_idx, "R5");

        // R10: idle count restarts after the error
        mode = 1'b0;
        send_idle(10, "R10");
        send_bit(1'b0, 1'b0, "R10");
        send_idle(11, "R10");
        build(11'h0F0, 4'd2, {16'h1234, 48'h0}, 1'b0);
        send_frame(fr.size(), 0, "R10");

        // R6: sixth dominant bit, once per run
        mode = 1'b1;
        err_mask = 3'b001;
        send_idle(11, "R6");
        for (int i = 0; i < 7; i++) send_bit(1'b0, i == 5, "R6");

        // R9: empty mask
        err_mask = 3'b000;
        send_idle(11, "R9");
        for (int i = 0; i < 6; i++) send_bit(1'b0, 1'b0, "R9");

        // R9: start mode ignores errors
        mode = 1'b0;
        err_mask = 3'b111;
        send_idle(11, "R9");
        build(11'h321, 4'd3, {24'hC0FFEE, 40'h0}, 1'b1);
        send_frame(fr.size(), 0, "R9");

        send_idle(2, "R11");
        repeat (4) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule